// File: doc/BRIEF.md
# Stack Call and Interrupt Sequencer

This block is the microsequencer an 8-bit processor core uses for every operation that moves data through the hardware stack. It covers subroutine call and return, return from interrupt, the software break trap, and pushing or pulling the accumulator and the status register. The stack sits in one fixed 256-byte page. An 8-bit pointer indexes it, and the pointer wraps around inside that page.

The surrounding core fetches the opcode itself. In that same cycle it raises `start` for one clock. With `start` it presents the operation code, the opcode's own address on `pc_in`, and the current stack pointer, accumulator and status. From the next cycle on, the sequencer owns the memory bus and makes exactly one access per cycle, in the same order as the real hardware, dummy reads included. One cycle after its last bus access it pulses `done`. At that point `pc_out`, `sp_out`, `a_out` and `p_out` hold the updated registers, and they keep those values until the next start. While idle it drives a read at `pc_out` and never writes.

Top module: `stack_seq`

## Requirements
- R1: A stack access uses address {0x01, sp}. A push writes at sp and then decrements sp. A pull increments sp and then reads at the new sp. sp wraps modulo 256 in both directions.
- R2: Call (op 0) starts from opcode address X and makes these accesses: read X+1 (low target byte), dummy stack read, write the high byte of X+2, write the low byte of X+2, read X+2 (high target byte). The PC becomes {high, low} and sp drops by 2.
- R3: Return (op 1) makes these accesses: dummy read of X+1, dummy stack read, pull low, pull high, then a read at the pulled address T. The PC becomes T+1, with a carry into the high byte, and sp rises by 2.
- R4: Return from interrupt (op 2) makes these accesses: dummy read of X+1, dummy stack read, pull status, pull PC low, pull PC high. The PC is the pulled value with no adjustment, and sp rises by 3.
- R5: Break (op 3) makes these accesses: dummy read of X+1, push high of X+2, push low of X+2, push status, read 0xFFFE (new PC low), read 0xFFFF (new PC high). sp drops by 3, and interrupt-disable (bit 2) is set after the push.
- R6: The status byte written by a break or a status push has bit 4 and bit 5 forced to 1. The other bits are the live flags.
- R7: Push accumulator (op 4) and push status (op 5) make a dummy read of X+1 followed by one stack write. Pull accumulator (op 6) and pull status (op 7) make a dummy read of X+1, a dummy stack read, and one pull. After any of these four, the PC is X+1.
- R8: Pull accumulator loads A with the pulled byte, sets zero (bit 1) when that byte is 0, and copies its bit 7 into negative (bit 7). The other status bits are unchanged.
- R9: When status is pulled (pull status or return from interrupt), bits 4 and 5 keep their previous values. The other six bits take the pulled byte.
- R10: `done` is high for exactly one cycle, the cycle after the last bus access. `busy` covers the bus accesses. When `busy` is low the bus is a read.
- R11: A `start` raised while `busy` is high is ignored. Registers an operation does not name (A, except for pull accumulator) keep their input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code (0 call .. 7 pull status) |
| pc_in | input | 16 | Address of the opcode byte |
| sp_in | input | 8 | Stack pointer at start |
| a_in | input | 8 | Accumulator at start |
| p_in | input | 8 | Status at start |
| rdata | input | 8 | Memory read data for the current address |
| busy | output | 1 | Sequencer owns the bus |
| done | output | 1 | One-cycle completion pulse |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| wdata | output | 8 | Write data |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| a_out | output | 8 | Updated accumulator |
| p_out | output | 8 | Updated status |

## Verification
The bench compares every bus cycle against its own model, so any dropped or reordered dummy read shifts the whole trace and shows up at once. Pushing at sp 0x00 and pulling at sp 0xFF exercises the pointer wrap: a design that carried into the page byte would address 0x0200 or 0x00FF. A call whose return address ends in 0xFF, followed by a return, checks the +1 carry into the high byte; a design that added only to the low byte would land 256 bytes short. Pulled status bytes of 0xFF and 0x30 check that bits 4 and 5 are held, pushed status bytes check that those bits are forced, and a start pulse during a busy push checks that the running trace is not disturbed.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_VECTOR = 16'hFFFE,
  parameter logic [7:0]  FORCE_MASK = 8'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [15:0] pc_in,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  p_in,
  input  logic [7:0]  rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] addr,
  output logic        rw,
  output logic [7:0]  wdata,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out,
  output logic [7:0]  a_out,
  output logic [7:0]  p_out
);
  localparam logic [2:0] OP_CALL = 3'd0, OP_RET = 3'd1, OP_RETI = 3'd2, OP_BRK = 3'd3,
                         OP_PSHA = 3'd4, OP_PSHP = 3'd5, OP_PLLA = 3'd6, OP_PLLP = 3'd7;
  localparam logic [15:0] VEC_HI = BRK_VECTOR + 16'd1;

  logic [2:0]  op_q, step;
  logic [15:0] pc_r;
  logic [7:0]  sp_r, a_r, p_r, lo_r;
  logic [15:0] stk;
  logic [7:0]  p_pulled;
  logic [2:0]  last;

  assign stk      = {STACK_PAGE, sp_r};
  assign p_pulled = (rdata & ~FORCE_MASK) | (p_r & FORCE_MASK);
  assign pc_out   = pc_r;
  assign sp_out   = sp_r;
  assign a_out    = a_r;
  assign p_out    = p_r;

  always_comb begin
    case (op_q)
      OP_BRK:           last = 3'd7;
      OP_PSHA, OP_PSHP: last = 3'd3;
      OP_PLLA, OP_PLLP: last = 3'd4;
      default:          last = 3'd6;
    endcase
  end

  always_comb begin
    addr  = pc_r;
    rw    = 1'b1;
    wdata = 8'h00;
    if (busy) begin
      case (op_q)
        OP_CALL: case (step)
          3'd3: addr = stk;
          3'd4: begin addr = stk; rw = 1'b0; wdata = pc_r[15:8]; end
          3'd5: begin addr = stk; rw = 1'b0; wdata = pc_r[7:0]; end
          default: ;
        endcase
        OP_RET: if (step >= 3'd3 && step <= 3'd5) addr = stk;
        OP_RETI: if (step >= 3'd3) addr = stk;
        OP_BRK: case (step)
          3'd3: begin addr = stk; rw = 1'b0; wdata = pc_r[15:8]; end
          3'd4: begin addr = stk; rw = 1'b0; wdata = pc_r[7:0]; end
          3'd5: begin addr = stk; rw = 1'b0; wdata = p_r | FORCE_MASK; end
          3'd6: addr = BRK_VECTOR;
          3'd7: addr = VEC_HI;
          default: ;
        endcase
        OP_PSHA, OP_PSHP: if (step == 3'd3) begin
          addr  = stk;
          rw    = 1'b0;
          wdata = (op_q == OP_PSHA) ? a_r : (p_r | FORCE_MASK);
        end
        default: if (step >= 3'd3) addr = stk;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= 3'd0;
      op_q <= OP_CALL;
      pc_r <= 16'h0000;
      sp_r <= 8'h00;
      a_r  <= 8'h00;
      p_r  <= 8'h00;
      lo_r <= 8'h00;
    end else if (!busy) begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        step <= 3'd2;
        op_q <= op;
        pc_r <= pc_in + 16'd1;
        sp_r <= sp_in;
        a_r  <= a_in;
        p_r  <= p_in;
      end
    end else begin
      step <= step + 3'd1;
      if (step == last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      case (op_q)
        OP_CALL: case (step)
          3'd2: begin lo_r <= rdata; pc_r <= pc_r + 16'd1; end
          3'd4, 3'd5: sp_r <= sp_r - 8'd1;
          3'd6: pc_r <= {rdata, lo_r};
          default: ;
        endcase
        OP_RET: case (step)
          3'd3: sp_r <= sp_r + 8'd1;
          3'd4: begin lo_r <= rdata; sp_r <= sp_r + 8'd1; end
          3'd5: pc_r <= {rdata, lo_r};
          3'd6: pc_r <= pc_r + 16'd1;
          default: ;
        endcase
        OP_RETI: case (step)
          3'd3: sp_r <= sp_r + 8'd1;
          3'd4: begin p_r <= p_pulled; sp_r <= sp_r + 8'd1; end
          3'd5: begin lo_r <= rdata; sp_r <= sp_r + 8'd1; end
          3'd6: pc_r <= {rdata, lo_r};
          default: ;
        endcase
        OP_BRK: case (step)
          3'd2: pc_r <= pc_r + 16'd1;
          3'd3, 3'd4: sp_r <= sp_r - 8'd1;
          3'd5: begin sp_r <= sp_r - 8'd1; p_r[2] <= 1'b1; end
          3'd6: lo_r <= rdata;
          3'd7: pc_r <= {rdata, lo_r};
          default: ;
        endcase
        OP_PSHA, OP_PSHP: if (step == 3'd3) sp_r <= sp_r - 8'd1;
        default: begin
          if (step == 3'd3) sp_r <= sp_r + 8'd1;
          if (step == 3'd4) begin
            if (op_q == OP_PLLA) begin
              a_r    <= rdata;
              p_r[1] <= (rdata == 8'h00);
              p_r[7] <= rdata[7];
            end else begin
              p_r <= p_pulled;
            end
          end
        end
      endcase
    end
  end
endmodule

module stack_seq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        rw,
  input logic [15:0] addr,
  input logic [7:0]  sp_out,
  input logic [7:0]  a_out,
  input logic [7:0]  p_out,
  input logic [2:0]  op_q
);
  p_push_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rw |=> sp_out == $past(sp_out) - 8'd1);
  p_write_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rw |-> addr[15:8] == STACK_PAGE);
  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rw);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_brk_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == 3'd3 |-> p_out[2]);
  p_pull_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == 3'd6 |-> p_out[1] == (a_out == 8'h00) && p_out[7] == a_out[7]);
endmodule

bind stack_seq stack_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rw(rw), .addr(addr),
  .sp_out(sp_out), .a_out(a_out), .p_out(p_out), .op_q(op_q)
);

// File: tb/stack_seq_bench.sv
`timescale 1ns/1ps
module stack_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [15:0] pc_in = 16'h0;
  logic [7:0] sp_in = 8'h0, a_in = 8'h0, p_in = 8'h0;
  logic [7:0] rdata;
  logic busy, done, rw;
  logic [15:0] addr, pc_out;
  logic [7:0] wdata, sp_out, a_out, p_out;
  logic [7:0] mem [0:65535];

  int checks = 0, errors = 0;
  int ea [8];
  bit er [8];
  logic [7:0] ew [8];
  int en;

  always #5 clk = ~clk;
  assign rdata = mem[addr];

  stack_seq u_stack_seq (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
    .sp_in(sp_in), .a_in(a_in), .p_in(p_in), .rdata(rdata), .busy(busy), .done(done),
    .addr(addr), .rw(rw), .wdata(wdata), .pc_out(pc_out), .sp_out(sp_out),
    .a_out(a_out), .p_out(p_out));

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add(int a, bit r, logic [7:0] w);
    ea[en] = a; er[en] = r; ew[en] = w; en++;
  endtask

  function automatic logic [7:0] held(logic [7:0] v, logic [7:0] old);
    return (v & 8'hCF) | (old & 8'h30);
  endfunction

  task automatic run(logic [2:0] o, logic [15:0] x, logic [7:0] s, logic [7:0] a,
                     logic [7:0] p, bit poke, string req);
    logic [15:0] ret, t, xpc;
    logic [7:0] xs, xa, xp, s1, s2, s3;
    en = 0; ret = x + 16'd2; xpc = x + 16'd1; xs = s; xa = a; xp = p;
    s1 = s + 8'd1; s2 = s + 8'd2; s3 = s + 8'd3;
    add(x + 1, 1, 0);
    case (o)
      3'd0: begin
        add({8'h01, s}, 1, 0); add({8'h01, s}, 0, ret[15:8]);
        add({8'h01, s - 8'd1}, 0, ret[7:0]); add(x + 2, 1, 0);
        xpc = {mem[x + 16'd2], mem[x + 16'd1]}; xs = s - 8'd2;
      end
      3'd1: begin
        add({8'h01, s}, 1, 0); add({8'h01, s1}, 1, 0); add({8'h01, s2}, 1, 0);
        t = {mem[{8'h01, s2}], mem[{8'h01, s1}]};
        add(t, 1, 0); xpc = t + 16'd1; xs = s2;
      end
      3'd2: begin
        add({8'h01, s}, 1, 0); add({8'h01, s1}, 1, 0); add({8'h01, s2}, 1, 0);
        add({8'h01, s3}, 1, 0);
        xp = held(mem[{8'h01, s1}], p);
        xpc = {mem[{8'h01, s3}], mem[{8'h01, s2}]}; xs = s3;
      end
      3'd3: begin
        add({8'h01, s}, 0, ret[15:8]); add({8'h01, s - 8'd1}, 0, ret[7:0]);
        add({8'h01, s - 8'd2}, 0, p | 8'h30); add(16'hFFFE, 1, 0); add(16'hFFFF, 1, 0);
        xpc = {mem[16'hFFFF], mem[16'hFFFE]}; xs = s - 8'd3; xp = p | 8'h04;
      end
      3'd4, 3'd5: begin
        add({8'h01, s}, 0, (o == 3'd4) ? a : (p | 8'h30)); xs = s - 8'd1;
      end
      default: begin
        add({8'h01, s}, 1, 0); add({8'h01, s1}, 1, 0); xs = s1;
        if (o == 3'd6) begin
          xa = mem[{8'h01, s1}];
          xp = p; xp[1] = (xa == 8'h00); xp[7] = xa[7];
        end else xp = held(mem[{8'h01, s1}], p);
      end
    endcase
    @(negedge clk);
    op = o; pc_in = x; sp_in = s; a_in = a; p_in = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < en; i++) begin
      check(busy == 1'b1 && addr == ea[i][15:0] && rw == er[i] && (er[i] || wdata == ew[i]),
            req, $sformatf("cycle %0d addr/rw/wdata", i + 2),
            {addr, 7'h0, rw, wdata}, {ea[i][15:0], 7'h0, er[i], ew[i]});
      if (!rw) mem[addr] = wdata;
      if (poke && i == 0) begin start = 1'b1; op = 3'd7; sp_in = 8'h55; end
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b1 && busy == 1'b0, "R10", "done pulse", {done, busy}, 2'b10);
    check(pc_out == xpc, req, "pc", pc_out, xpc);
    check(sp_out == xs, "R1", "sp", sp_out, xs);
    check(a_out == xa, (o == 3'd6) ? "R8" : "R11", "a", a_out, xa);
    check(p_out == xp, req, "status", p_out, xp);
    @(negedge clk);
    check(done == 1'b0 && rw == 1'b1, "R10", "idle after done", {done, rw}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    mem[16'h1235] = 8'h78; mem[16'h1236] = 8'h56;
    mem[16'hFFFE] = 8'h00; mem[16'hFFFF] = 8'h80;
    mem[16'h40FE] = 8'hCD; mem[16'h40FF] = 8'hAB;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && rw == 1 && sp_out == 0 && pc_out == 0, "R10", "reset state",
          {busy, done, rw}, 3'b001);
    rst_n = 1'b1;
    run(3'd0, 16'h1234, 8'hFD, 8'h11, 8'h00, 0, "R2");
    run(3'd1, 16'h5678, 8'hFB, 8'h11, 8'h00, 0, "R3");
    run(3'd0, 16'h40FD, 8'h00, 8'h22, 8'h00, 0, "R2");
    run(3'd1, 16'hABCD, 8'hFE, 8'h22, 8'h00, 0, "R3");
    run(3'd4, 16'h3000, 8'h00, 8'h80, 8'h00, 0, "R7");
    run(3'd6, 16'h3001, 8'hFF, 8'h00, 8'h02, 0, "R8");
    run(3'd4, 16'h3002, 8'h10, 8'h00, 8'h00, 0, "R7");
    run(3'd6, 16'h3003, 8'h0F, 8'h5A, 8'h80, 0, "R8");
    run(3'd5, 16'h3004, 8'h20, 8'h00, 8'h01, 0, "R6");
    run(3'd4, 16'h3005, 8'h1F, 8'hFF, 8'h00, 0, "R7");
    run(3'd7, 16'h3006, 8'h1E, 8'h00, 8'h00, 0, "R9");
    run(3'd3, 16'h2000, 8'hFF, 8'h33, 8'h00, 0, "R5");
    run(3'd2, 16'h8000, 8'hFC, 8'h33, 8'h34, 0, "R4");
    run(3'd5, 16'h3007, 8'h01, 8'h00, 8'hC3, 0, "R6");
    run(3'd7, 16'h3008, 8'h00, 8'h00, 8'h30, 0, "R9");
    run(3'd4, 16'h3009, 8'h40, 8'h77, 8'h00, 1, "R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule